// File: doc/BRIEF.md
# Early Branch Resolution Unit

This block settles conditional branches and jumps while the control instruction sits in the decode stage of a five-stage integer pipeline, so only one fetch slot is lost to a taken control transfer rather than three. It holds the fetch/decode pipeline register, classifies the instruction it holds, tests the register operand for zero with dedicated logic, and forms the taken-path address with its own adder. Two results go back to fetch: a redirect flag that selects the computed target in place of the sequential address, and the target itself.

What happens to the instruction that was fetched behind a taken branch depends on a mode input. In delay-slot mode that successor always runs. In predict-not-taken mode it is squashed: the pipeline register is loaded with an all-zero no-op whose valid flag is clear, so it carries no register or memory write enable. The register file read uses the first-source field of the instruction shown on `id_instr_o` and returns the operand on `rs_value_i` in the same cycle. Operand forwarding into the zero test and dynamic prediction are not part of the block.

Top module: `early_branch_unit`

## Requirements
- R1: While `rst_ni` is low, `id_instr_o` is 32'h0, `id_valid_o` is 0, and both `redirect_o` and `squash_o` are 0.
- R2: With no squash, every rising clock edge copies `if_instr_i` into `id_instr_o` and `if_pc4_i` into `id_pc4_o`, and sets `id_valid_o` to 1.
- R3: Opcode field bits 31:26 equal to 6'h04 is branch-if-zero and is taken when `rs_value_i` is zero. 6'h05 is branch-if-nonzero and is taken when `rs_value_i` is not zero.
- R4: For either branch opcode, `target_o` is `id_pc4_o` plus the sign-extended immediate in bits 15:0, shifted left by two.
- R5: Opcodes 6'h02 (jump) and 6'h03 (jump-and-link) always redirect. `target_o` is the upper four bits of `id_pc4_o`, then instruction bits 25:0, then two zero bits.
- R6: A taken control instruction raises `redirect_o` in the same cycle in which it is held in decode, with no added wait cycles.
- R7: When `delay_slot_mode_i` is 0, `squash_o` equals `redirect_o`. On the next edge the pipeline register loads 32'h0 with `id_valid_o` at 0, and `id_pc4_o` still takes `if_pc4_i`.
- R8: When `delay_slot_mode_i` is 1, `squash_o` stays 0, and the instruction fetched behind a taken branch enters decode with `id_valid_o` at 1.
- R9: An instruction with any other opcode, an invalid instruction, or a branch whose condition fails drives both `redirect_o` and `squash_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| delay_slot_mode_i | input | 1 | 1: delay-slot mode, 0: predict-not-taken with squash |
| if_instr_i | input | 32 | Instruction leaving fetch |
| if_pc4_i | input | XLEN | Sequential address of that instruction plus four |
| rs_value_i | input | XLEN | First-source register value for the instruction in decode |
| id_instr_o | output | 32 | Instruction held in decode |
| id_pc4_o | output | XLEN | Address plus four of the instruction in decode |
| id_valid_o | output | 1 | Decode instruction may write registers or memory |
| redirect_o | output | 1 | Next-PC select: 1 takes `target_o` |
| target_o | output | XLEN | Computed branch or jump target |
| squash_o | output | 1 | Turn the instruction now in fetch into a no-op |

## Verification
The properties assume that `rs_value_i` belongs to the instruction currently held in decode and is already final in that cycle, because no forwarding path feeds the zero test. They also assume that the mode input and the fetch inputs are stable around each rising edge. The stimulus changes every input only on the falling edge. Whenever it has the operand to pick, it picks the value the register file would return for the instruction already in decode. Long random runs switch the mode only between edges.

// File: rtl/ebr_pkg.sv
package ebr_pkg;

   localparam int INSTR_W  = 32;
   localparam int OPC_W    = 6;
   localparam int OPC_LSB  = 26;
   localparam int IMM_W    = 16;
   localparam int JIDX_W   = 26;
   localparam int JHI_W    = 4;

   localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;
   localparam logic [OPC_W-1:0] OPC_JLINK = 6'h03;
   localparam logic [OPC_W-1:0] OPC_BEQZ  = 6'h04;
   localparam logic [OPC_W-1:0] OPC_BNEZ  = 6'h05;

   localparam logic [INSTR_W-1:0] NOP_WORD = '0;

   typedef enum logic [1:0] {
      CTL_NONE = 2'd0,
      CTL_BEQZ = 2'd1,
      CTL_BNEZ = 2'd2,
      CTL_JUMP = 2'd3
   } ctl_kind_e;

   function automatic ctl_kind_e classify(input logic [OPC_W-1:0] opc);
      ctl_kind_e k;
      unique case (opc)
         OPC_BEQZ:            k = CTL_BEQZ;
         OPC_BNEZ:            k = CTL_BNEZ;
         OPC_JUMP, OPC_JLINK: k = CTL_JUMP;
         default:             k = CTL_NONE;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/ebr_ifid_reg.sv
module ebr_ifid_reg
   import ebr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               squash_i,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [XLEN-1:0]    pc4_i,
   output logic [INSTR_W-1:0] instr_o,
   output logic [XLEN-1:0]    pc4_o,
   output logic               valid_o
);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         instr_o <= NOP_WORD;
         pc4_o   <= '0;
         valid_o <= 1'b0;
      end else begin
         pc4_o <= pc4_i;
         if (squash_i) begin
            instr_o <= NOP_WORD;
            valid_o <= 1'b0;
         end else begin
            instr_o <= instr_i;
            valid_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ebr_ctl_decode.sv
module ebr_ctl_decode
   import ebr_pkg::*;
(
   input  logic [INSTR_W-1:0] instr_i,
   input  logic               valid_i,
   output ctl_kind_e          kind_o,
   output logic [IMM_W-1:0]   imm_o,
   output logic [JIDX_W-1:0]  jidx_o
);

   logic [OPC_W-1:0] opc;

   always_comb begin
      opc    = instr_i[OPC_LSB +: OPC_W];
      kind_o = valid_i ? classify(opc) : CTL_NONE;
      imm_o  = instr_i[IMM_W-1:0];
      jidx_o = instr_i[JIDX_W-1:0];
   end

endmodule

// File: rtl/ebr_zero_test.sv
module ebr_zero_test #(
   parameter int XLEN    = 32,
   parameter bit USE_TREE = 1'b1,
   parameter int CHUNK   = 8
) (
   input  logic [XLEN-1:0] val_i,
   output logic            zero_o
);

   localparam int NCHUNK = XLEN / CHUNK;

   generate
      if (CHUNK < 1 || (XLEN % CHUNK) != 0) begin : g_bad_chunk
         $error("ebr_zero_test: CHUNK must divide XLEN");
      end

      if (USE_TREE) begin : g_tree
         logic [NCHUNK-1:0] part_nz;
         for (genvar g = 0; g < NCHUNK; g++) begin : g_part
            assign part_nz[g] = |val_i[g*CHUNK +: CHUNK];
         end
         assign zero_o = ~|part_nz;
      end else begin : g_flat
         assign zero_o = (val_i == '0);
      end
   endgenerate

endmodule

// File: rtl/ebr_target_gen.sv
module ebr_target_gen
   import ebr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0]   pc4_i,
   input  ctl_kind_e         kind_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [JIDX_W-1:0] jidx_i,
   output logic [XLEN-1:0]   target_o
);

   localparam int SEXT_W  = XLEN - IMM_W - 2;
   localparam int JLOW_W  = JIDX_W + 2;
   localparam int JKEEP_W = XLEN - JLOW_W;

   logic [XLEN-1:0] br_off;
   logic [XLEN-1:0] br_tgt;
   logic [XLEN-1:0] jmp_tgt;

   always_comb begin
      br_off   = {{SEXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
      br_tgt   = pc4_i + br_off;
      jmp_tgt  = {pc4_i[XLEN-1 -: JKEEP_W], jidx_i, 2'b00};
      target_o = (kind_i == CTL_JUMP) ? jmp_tgt : br_tgt;
   end

endmodule

// File: rtl/early_branch_unit.sv
module early_branch_unit
   import ebr_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter bit ZT_TREE   = 1'b1,
   parameter int ZT_CHUNK  = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               delay_slot_mode_i,
   input  logic [INSTR_W-1:0] if_instr_i,
   input  logic [XLEN-1:0]    if_pc4_i,
   input  logic [XLEN-1:0]    rs_value_i,
   output logic [INSTR_W-1:0] id_instr_o,
   output logic [XLEN-1:0]    id_pc4_o,
   output logic               id_valid_o,
   output logic               redirect_o,
   output logic [XLEN-1:0]    target_o,
   output logic               squash_o
);

   generate
      if (XLEN < JIDX_W + 2 + JHI_W) begin : g_bad_xlen
         $error("early_branch_unit: XLEN too small for jump target");
      end
   endgenerate

   ctl_kind_e         kind;
   logic [IMM_W-1:0]  imm;
   logic [JIDX_W-1:0] jidx;
   logic              rs_zero;
   logic              taken;

   ebr_ifid_reg #(.XLEN(XLEN)) u_ifid (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .squash_i (squash_o),
      .instr_i  (if_instr_i),
      .pc4_i    (if_pc4_i),
      .instr_o  (id_instr_o),
      .pc4_o    (id_pc4_o),
      .valid_o  (id_valid_o)
   );

   ebr_ctl_decode u_dec (
      .instr_i (id_instr_o),
      .valid_i (id_valid_o),
      .kind_o  (kind),
      .imm_o   (imm),
      .jidx_o  (jidx)
   );

   ebr_zero_test #(.XLEN(XLEN), .USE_TREE(ZT_TREE), .CHUNK(ZT_CHUNK)) u_zt (
      .val_i  (rs_value_i),
      .zero_o (rs_zero)
   );

   ebr_target_gen #(.XLEN(XLEN)) u_tgt (
      .pc4_i    (id_pc4_o),
      .kind_i   (kind),
      .imm_i    (imm),
      .jidx_i   (jidx),
      .target_o (target_o)
   );

   always_comb begin
      unique case (kind)
         CTL_BEQZ: taken = rs_zero;
         CTL_BNEZ: taken = ~rs_zero;
         CTL_JUMP: taken = 1'b1;
         default:  taken = 1'b0;
      endcase
      redirect_o = taken;
      squash_o   = taken & ~delay_slot_mode_i;
   end

endmodule

// File: rtl/ebr_checker.sv
module ebr_checker #(
   parameter int XLEN = 32
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            delay_slot_mode_i,
   input logic [31:0]     id_instr_o,
   input logic            id_valid_o,
   input logic [XLEN-1:0] rs_value_i,
   input logic            redirect_o,
   input logic            squash_o
);

   // R7
   squash_loads_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      squash_o |=> (!id_valid_o && id_instr_o == 32'h0));

   // R7
   pnt_taken_squash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!delay_slot_mode_i && redirect_o) |-> squash_o);

   // R8
   slot_mode_no_squash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      delay_slot_mode_i |-> !squash_o);

   // R9
   squash_needs_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      squash_o |-> redirect_o);

   // R5
   jump_always_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (id_valid_o && (id_instr_o[31:26] == 6'h02 || id_instr_o[31:26] == 6'h03)) |-> redirect_o);

   // R3
   beqz_nonzero_falls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (id_instr_o[31:26] == 6'h04 && rs_value_i != '0) |-> !redirect_o);

   // R3
   bnez_zero_falls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (id_instr_o[31:26] == 6'h05 && rs_value_i == '0) |-> !redirect_o);

endmodule

bind early_branch_unit ebr_checker #(.XLEN(XLEN)) u_ebr_chk (
   .clk_i             (clk_i),
   .rst_ni            (rst_ni),
   .delay_slot_mode_i (delay_slot_mode_i),
   .id_instr_o        (id_instr_o),
   .id_valid_o        (id_valid_o),
   .rs_value_i        (rs_value_i),
   .redirect_o        (redirect_o),
   .squash_o          (squash_o)
);

// File: tb/early_branch_unit_tb_top.sv
`timescale 1ns/1ps
module early_branch_unit_tb_top;

   logic        clk_i = 1'b0;
   logic        rst_ni;
   logic        delay_slot_mode_i;
   logic [31:0] if_instr_i;
   logic [31:0] if_pc4_i;
   logic [31:0] rs_value_i;
   logic [31:0] id_instr_o;
   logic [31:0] id_pc4_o;
   logic        id_valid_o;
   logic        redirect_o;
   logic [31:0] target_o;
   logic        squash_o;

   always #5 clk_i = ~clk_i;

   early_branch_unit dut_i (
      .clk_i             (clk_i),
      .rst_ni            (rst_ni),
      .delay_slot_mode_i (delay_slot_mode_i),
      .if_instr_i        (if_instr_i),
      .if_pc4_i          (if_pc4_i),
      .rs_value_i        (rs_value_i),
      .id_instr_o        (id_instr_o),
      .id_pc4_o          (id_pc4_o),
      .id_valid_o        (id_valid_o),
      .redirect_o        (redirect_o),
      .target_o          (target_o),
      .squash_o          (squash_o)
   );

   int nvec  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   // reference state of the decode slot
   logic [31:0] m_instr = '0;
   logic [31:0] m_pc4   = '0;
   logic        m_valid = 1'b0;
   bit          m_was_sq = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] mk(input logic [5:0] opc, input logic [25:0] rest);
      return {opc, rest};
   endfunction

   // caller is just after a falling edge
   task automatic step(input logic [31:0] ins, input logic [31:0] p4,
                       input logic [31:0] rs, input logic mode);
      logic [5:0]  op;
      bit          ctl;
      bit          tk;
      bit          exp_sq;
      logic [31:0] tgt;
      string       rq;
      if_instr_i = ins;
      if_pc4_i = p4;
      rs_value_i = rs;
      delay_slot_mode_i = mode;
      #1;
      op = m_instr[31:26];
      ctl = 1'b0;
      tk = 1'b0;
      tgt = '0;
      rq = "R9";
      if (m_valid) begin
         if (op == 6'h04 || op == 6'h05) begin
            ctl = 1'b1;
            tk = (op == 6'h04) ? (rs == 0) : (rs != 0);
            tgt = m_pc4 + {{14{m_instr[15]}}, m_instr[15:0], 2'b00};
            rq = tk ? "R3" : "R9";
         end else if (op == 6'h02 || op == 6'h03) begin
            ctl = 1'b1;
            tk = 1'b1;
            tgt = {m_pc4[31:28], m_instr[25:0], 2'b00};
            rq = "R5";
         end
      end
      exp_sq = tk && !mode;
      chk(id_instr_o === m_instr, m_was_sq ? "R7 instr" : "R2 instr", id_instr_o, m_instr);
      chk(id_valid_o === m_valid, m_was_sq ? "R7 valid" : (mode ? "R8 valid" : "R2 valid"),
          {31'b0, id_valid_o}, {31'b0, m_valid});
      chk(id_pc4_o === m_pc4, "R2 pc4", id_pc4_o, m_pc4);
      chk(redirect_o === tk, rq, {31'b0, redirect_o}, {31'b0, tk});
      chk(squash_o === exp_sq, mode ? "R8 squash" : "R7 squash", {31'b0, squash_o}, {31'b0, exp_sq});
      if (ctl && tk)
         chk(redirect_o === 1'b1, "R6 same-cycle redirect", {31'b0, redirect_o}, 32'h1);
      if (ctl)
         chk(target_o === tgt, (op == 6'h02 || op == 6'h03) ? "R5 target" : "R4 target", target_o, tgt);
      @(posedge clk_i);
      m_pc4 = p4;
      m_was_sq = exp_sq;
      if (exp_sq) begin
         m_instr = '0;
         m_valid = 1'b0;
      end else begin
         m_instr = ins;
         m_valid = 1'b1;
      end
      @(negedge clk_i);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   localparam logic [31:0] ALU_A = 32'h0022_1820;
   localparam logic [31:0] ALU_B = 32'h2001_0005;

   initial begin
      rst_ni = 1'b0;
      delay_slot_mode_i = 1'b0;
      if_instr_i = mk(6'h02, 26'h1);
      if_pc4_i = 32'h100;
      rs_value_i = '0;
      repeat (3) @(negedge clk_i);
      #1;
      // R1 reset state
      chk(id_instr_o === 32'h0, "R1 instr", id_instr_o, 32'h0);
      chk(id_valid_o === 1'b0, "R1 valid", {31'b0, id_valid_o}, 32'h0);
      chk(redirect_o === 1'b0, "R1 redirect", {31'b0, redirect_o}, 32'h0);
      chk(squash_o === 1'b0, "R1 squash", {31'b0, squash_o}, 32'h0);
      rst_ni = 1'b1;

      // predict-not-taken: plain ops, then BEQZ taken (R3, R4, R7)
      step(ALU_A, 32'h0000_1004, 32'h0, 1'b0);
      step(mk(6'h04, {5'd3, 5'd0, 16'h0010}), 32'h0000_1008, 32'h5, 1'b0);
      step(ALU_B, 32'h0000_100C, 32'h0, 1'b0);   // beqz in ID, operand zero: taken
      step(ALU_A, 32'h0000_1050, 32'h0, 1'b0);   // squashed slot in ID
      // BEQZ not taken, negative offset
      step(mk(6'h04, {5'd2, 5'd0, 16'hFFF0}), 32'h0000_1054, 32'h0, 1'b0);
      step(ALU_B, 32'h0000_1058, 32'h7, 1'b0);
      // BNEZ taken with negative offset
      step(mk(6'h05, {5'd2, 5'd0, 16'hFFFE}), 32'h0000_105C, 32'h0, 1'b0);
      step(ALU_A, 32'h0000_1060, 32'h1, 1'b0);
      // BNEZ not taken
      step(mk(6'h05, {5'd4, 5'd0, 16'h0040}), 32'h0000_1058, 32'h0, 1'b0);
      step(ALU_B, 32'h0000_105C, 32'h0, 1'b0);
      // jump and jump-and-link, high PC bits kept (R5)
      step(mk(6'h02, 26'h3FF_FFFF), 32'hA000_0004, 32'h0, 1'b0);
      step(ALU_A, 32'hA000_0008, 32'h0, 1'b0);
      step(mk(6'h03, 26'h000_0123), 32'hF000_0000, 32'h0, 1'b1);
      // delay-slot mode: successor must run (R8)
      step(ALU_B, 32'hF000_0004, 32'h0, 1'b1);
      step(mk(6'h04, {5'd1, 5'd0, 16'h0004}), 32'h0000_2004, 32'h0, 1'b1);
      step(mk(6'h05, {5'd1, 5'd0, 16'h0008}), 32'h0000_2008, 32'h0, 1'b1);
      step(ALU_A, 32'h0000_2018, 32'h9, 1'b1);   // branch in slot of branch
      step(ALU_B, 32'h0000_201C, 32'h0, 1'b1);

      // random mix, mode flips every 64 steps
      for (int i = 0; i < 600; i++) begin
         logic [31:0] ins;
         logic [31:0] rs;
         int sel;
         sel = $urandom_range(0, 5);
         case (sel)
            0: ins = mk(6'h04, 26'($urandom));
            1: ins = mk(6'h05, 26'($urandom));
            2: ins = mk(6'h02, 26'($urandom));
            3: ins = mk(6'h03, 26'($urandom));
            4: ins = mk(6'h08, 26'($urandom));
            default: ins = mk(6'h00, 26'($urandom));
         endcase
         rs = ($urandom_range(0, 1) == 0) ? 32'h0 : $urandom;
         step(ins, $urandom, rs, ((i / 64) % 2) == 1);
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule